// File: doc/BRIEF.md
# Double-Precision Normalized Mantissa Extractor

This block takes IEEE-754 double-precision values and, for each one, returns the significand rescaled into one of four intervals. A sign-control field sets the sign of the result. It also decides how negative numbers, zeros, infinities and NaNs are treated. A 4-bit immediate carries both controls. The exponent of a finite input is replaced by 1023+k, where k is 0 or -1. The fraction bits are kept. Subnormal inputs are first renormalized so that their leading one becomes the hidden bit.

A vector wrapper applies the per-value unit to 2, 4 or 8 lanes of 64 bits. Each lane has a write mask bit, and a masked-off lane is either merged (it keeps its prior destination value) or zeroed. The wrapper can also broadcast lane 0 of the source to every lane. Lanes beyond the selected vector length are cleared. The wrapper ORs an invalid flag and a denormal flag over the lanes it computes. With the default configuration, results, flags and a valid strobe are registered once.

Top module: `mant_vec`

## Requirements
- R1: imm_i[1:0] is the interval code and imm_i[3:2] is the sign control, with sc0 = imm_i[2] and sc1 = imm_i[3].
- R2: A finite nonzero input that is not rejected by R5 returns exponent field 0x3FF when k=0 and 0x3FE when k=-1, followed by the input's normalized 52 fraction bits. The interval code sets k. Code 0 ([1,2)) gives k=0. Code 1 ([1/2,2)) gives k=-1 exactly when the biased exponent is even. Code 2 ([1/2,1)) always gives k=-1. Code 3 ([3/4,3/2)) gives k=-1 exactly when the top normalized fraction bit is 1.
- R3: For a subnormal input, the fraction is shifted left until its leading one becomes the hidden bit. Its effective biased exponent is 1 minus the shift count, and that value decides the parity for R2. A subnormal input on a computed lane sets den_o.
- R4: A NaN input returns itself with fraction bit 51 forced to 1, whatever the interval code. A signaling NaN (fraction bit 51 clear) also sets inv_o.
- R5: When sc1=1, a negative input that is neither a zero nor a NaN (this includes negative infinity) returns 0xFFF8000000000000 and sets inv_o.
- R6: +0 and +infinity return +1.0 (0x3FF0000000000000). -0 returns +1.0 when sc0=1 and -1.0 (0xBFF0000000000000) when sc0=0. -infinity returns the same as -0 when sc1=0. A finite result has sign 0 when sc0=1 and otherwise keeps the input sign.
- R7: vl_sel_i values 0, 1, 2 and 3 make 2, 4, 8 and 8 lanes active. Lane j occupies bits 64j+63:64j. Every bit above the active lanes reads zero.
- R8: With mask_en_i=0 every active lane is computed. With mask_en_i=1, an active lane whose mask_i bit is clear keeps old_i's lane value when zero_mask_i=0 and reads zero when zero_mask_i=1.
- R9: With bcast_i=1, every active lane computes from src_i[63:0].
- R10: inv_o and den_o are the OR of the per-lane flags over computed lanes only. Masked-off and inactive lanes never raise them.
- R11: Outputs are registered. dst_o, inv_o and den_o take the result of inputs presented with valid_i=1 one cycle later, and valid_o pulses in that cycle. Outputs hold while valid_i=0 and are all zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Operation present this cycle |
| imm_i | input | 4 | Interval code [1:0], sign control [3:2] |
| vl_sel_i | input | 2 | Vector length select (2/4/8/8 lanes) |
| mask_en_i | input | 1 | Enable per-lane write mask |
| zero_mask_i | input | 1 | 1: zero masked lanes, 0: merge |
| bcast_i | input | 1 | Use lane 0 of the source for all lanes |
| mask_i | input | 8 | Per-lane write mask |
| src_i | input | 512 | Source lanes |
| old_i | input | 512 | Prior destination lanes for merging |
| valid_o | output | 1 | Result valid |
| dst_o | output | 512 | Result lanes |
| inv_o | output | 1 | Invalid flag over computed lanes |
| den_o | output | 1 | Denormal flag over computed lanes |

## Verification
The only state in the block is the output register, so any fault appears at dst_o or the flags on the cycle after the operation. A wrong k choice shows as an exponent field of 0x3FE where 0x3FF is expected, or the reverse. A wrong leading-zero count on a subnormal shows as a shifted fraction and can also flip the parity decision. A wrong lane-enable or length decode shows as a lane that is merged, zeroed or computed when it should not be. A lane that leaks into the flags shows as inv_o or den_o set with no computed lane to cause it. The bench sweeps every immediate against a set of special, normal and subnormal values and every mask pattern in both masking modes, and it compares each result with an arithmetic model.

// File: rtl/mant_pkg.sv
package mant_pkg;
  localparam int W64    = 64;
  localparam int EXP_W  = 11;
  localparam int FRAC_W = 52;
  localparam int LZ_W   = $clog2(FRAC_W + 1);

  localparam logic [EXP_W-1:0] EXP_ONE  = 11'h3FF;
  localparam logic [EXP_W-1:0] EXP_HALF = 11'h3FE;
  localparam logic [EXP_W-1:0] EXP_MAX  = 11'h7FF;

  localparam logic [W64-1:0] DEF_QNAN = 64'hFFF8_0000_0000_0000;
  localparam logic [W64-1:0] POS_ONE  = 64'h3FF0_0000_0000_0000;
  localparam logic [W64-1:0] NEG_ONE  = 64'hBFF0_0000_0000_0000;

  typedef enum logic [1:0] {
    IV_ONE_TWO  = 2'd0,
    IV_HALF_TWO = 2'd1,
    IV_HALF_ONE = 2'd2,
    IV_3Q_3H    = 2'd3
  } intv_e;

  typedef struct packed {
    logic inv;
    logic den;
  } lane_flags_t;
endpackage

// File: rtl/mant_lzc.sv
module mant_lzc #(
  parameter int WIDTH = 52,
  localparam int CNT_W = $clog2(WIDTH + 1)
) (
  input  logic [WIDTH-1:0] vec_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_comb begin
    cnt_o = CNT_W'(WIDTH);
    // highest set bit wins, as it is visited last
    for (int i = 0; i < WIDTH; i++) begin
      if (vec_i[i]) cnt_o = CNT_W'(WIDTH - 1 - i);
    end
  end
endmodule

// File: rtl/mant_lane.sv
module mant_lane
  import mant_pkg::*;
(
  input  logic [W64-1:0] src_i,
  input  logic [1:0]     intv_i,
  input  logic [1:0]     sc_i,
  output logic [W64-1:0] res_o,
  output lane_flags_t    flags_o
);
  logic              sgn;
  logic [EXP_W-1:0]  ex;
  logic [FRAC_W-1:0] fr;
  assign {sgn, ex, fr} = src_i;

  logic fr_zero, is_nan, is_snan, is_inf, is_zero, is_sub;
  assign fr_zero = (fr == '0);
  assign is_nan  = (ex == EXP_MAX) && !fr_zero;
  assign is_snan = is_nan && !fr[FRAC_W-1];
  assign is_inf  = (ex == EXP_MAX) && fr_zero;
  assign is_zero = (ex == '0) && fr_zero;
  assign is_sub  = (ex == '0) && !fr_zero;

  logic [LZ_W-1:0] lz;
  mant_lzc #(.WIDTH(FRAC_W)) u_lzc (
    .vec_i(fr),
    .cnt_o(lz)
  );

  // subnormal: shift past leading one; effective biased exponent = -lz
  logic [LZ_W:0]     sh;
  logic [FRAC_W-1:0] fr_n;
  logic              exp_even;
  assign sh       = {1'b0, lz} + (LZ_W+1)'(1);
  assign fr_n     = is_sub ? (fr << sh) : fr;
  assign exp_even = is_sub ? ~lz[0] : ~ex[0];

  intv_e iv;
  logic  k_neg;
  assign iv = intv_e'(intv_i);

  always_comb begin
    unique case (iv)
      IV_ONE_TWO:  k_neg = 1'b0;
      IV_HALF_TWO: k_neg = exp_even;
      IV_HALF_ONE: k_neg = 1'b1;
      IV_3Q_3H:    k_neg = fr_n[FRAC_W-1];
      default:     k_neg = 1'b0;
    endcase
  end

  always_comb begin
    flags_o.den = is_sub;
    flags_o.inv = 1'b0;
    if (is_nan) begin
      res_o       = src_i | (W64'(1) << (FRAC_W - 1));
      flags_o.inv = is_snan;
    end else if (sgn && sc_i[1] && !is_zero) begin
      res_o       = DEF_QNAN;
      flags_o.inv = 1'b1;
    end else if (is_inf || is_zero) begin
      res_o = (sgn && !sc_i[0]) ? NEG_ONE : POS_ONE;
    end else begin
      res_o = {sgn & ~sc_i[0], (k_neg ? EXP_HALF : EXP_ONE), fr_n};
    end
  end
endmodule

// File: rtl/mant_vec.sv
module mant_vec
  import mant_pkg::*;
#(
  parameter int LANES   = 8,
  parameter bit REG_OUT = 1'b1,
  localparam int DW     = LANES * W64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [3:0]       imm_i,
  input  logic [1:0]       vl_sel_i,
  input  logic             mask_en_i,
  input  logic             zero_mask_i,
  input  logic             bcast_i,
  input  logic [LANES-1:0] mask_i,
  input  logic [DW-1:0]    src_i,
  input  logic [DW-1:0]    old_i,
  output logic             valid_o,
  output logic [DW-1:0]    dst_o,
  output logic             inv_o,
  output logic             den_o
);
  localparam int CNT_W = $clog2(LANES) + 4;

  logic [CNT_W-1:0] lane_cnt;
  assign lane_cnt = CNT_W'(2) << vl_sel_i;

  logic [DW-1:0]    dst_d;
  logic [LANES-1:0] inv_v, den_v;

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic [W64-1:0] l_src, l_res, l_old;
    lane_flags_t    l_flg;
    logic           l_act, l_en;

    assign l_src = bcast_i ? src_i[W64-1:0] : src_i[j*W64 +: W64];
    assign l_old = old_i[j*W64 +: W64];
    assign l_act = (lane_cnt > CNT_W'(j));
    assign l_en  = l_act && (!mask_en_i || mask_i[j]);

    mant_lane u_lane (
      .src_i  (l_src),
      .intv_i (imm_i[1:0]),
      .sc_i   (imm_i[3:2]),
      .res_o  (l_res),
      .flags_o(l_flg)
    );

    always_comb begin
      if (!l_act)           dst_d[j*W64 +: W64] = '0;
      else if (l_en)        dst_d[j*W64 +: W64] = l_res;
      else if (zero_mask_i) dst_d[j*W64 +: W64] = '0;
      else                  dst_d[j*W64 +: W64] = l_old;
    end

    assign inv_v[j] = l_en & l_flg.inv;
    assign den_v[j] = l_en & l_flg.den;
  end

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_o <= 1'b0;
        dst_o   <= '0;
        inv_o   <= 1'b0;
        den_o   <= 1'b0;
      end else begin
        valid_o <= valid_i;
        if (valid_i) begin
          dst_o <= dst_d;
          inv_o <= |inv_v;
          den_o <= |den_v;
        end
      end
    end
  end else begin : g_comb
    assign valid_o = valid_i;
    assign dst_o   = dst_d;
    assign inv_o   = |inv_v;
    assign den_o   = |den_v;
  end
endmodule

// File: rtl/mant_vec_chk.sv
module mant_vec_chk #(
  parameter int LANES   = 8,
  parameter bit REG_OUT = 1'b1,
  localparam int DW     = LANES * 64
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          valid_i,
  input logic [3:0]    imm_i,
  input logic [1:0]    vl_sel_i,
  input logic          mask_en_i,
  input logic          zero_mask_i,
  input logic          mask0_i,
  input logic [63:0]   src0_i,
  input logic [63:0]   old0_i,
  input logic          valid_o,
  input logic [DW-1:0] dst_o,
  input logic          inv_o
);
  logic en0, nan0, zero0, norm0;
  assign en0   = !mask_en_i || mask0_i;
  assign nan0  = (src0_i[62:52] == 11'h7FF) && (src0_i[51:0] != '0);
  assign zero0 = (src0_i[62:0] == '0);
  assign norm0 = (src0_i[62:52] != '0) && (src0_i[62:52] != 11'h7FF);

  if (REG_OUT) begin : g_seq
    a_r11_valid_delay: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_o == $past(valid_i));

    a_r8_merge_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(valid_i && mask_en_i && !zero_mask_i && !mask0_i)
      |-> dst_o[63:0] == $past(old0_i));

    a_r8_zero_fill: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(valid_i && mask_en_i && zero_mask_i && !mask0_i)
      |-> dst_o[63:0] == '0);

    a_r5_neg_invalid: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(valid_i && en0 && imm_i[3] && src0_i[63] && !zero0 && !nan0)
      |-> (dst_o[63:0] == 64'hFFF8_0000_0000_0000) && inv_o);

    a_r2_exp_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(valid_i && en0 && !imm_i[3] && norm0)
      |-> (dst_o[62:52] == 11'h3FF || dst_o[62:52] == 11'h3FE)
          && dst_o[51:0] == $past(src0_i[51:0]));

    if (LANES > 2) begin : g_upper
      a_r7_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(valid_i && vl_sel_i == 2'd0) |-> dst_o[DW-1:128] == '0);
    end
  end
endmodule

bind mant_vec mant_vec_chk #(.LANES(LANES), .REG_OUT(REG_OUT)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .valid_i    (valid_i),
  .imm_i      (imm_i),
  .vl_sel_i   (vl_sel_i),
  .mask_en_i  (mask_en_i),
  .zero_mask_i(zero_mask_i),
  .mask0_i    (mask_i[0]),
  .src0_i     (src_i[63:0]),
  .old0_i     (old_i[63:0]),
  .valid_o    (valid_o),
  .dst_o      (dst_o),
  .inv_o      (inv_o)
);

// File: tb/tb_mant_vec.sv
module tb_mant_vec;
  localparam int NV = 24;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         valid_i = 1'b0;
  logic [3:0]   imm_i = '0;
  logic [1:0]   vl_sel_i = '0;
  logic         mask_en_i = 1'b0;
  logic         zero_mask_i = 1'b0;
  logic         bcast_i = 1'b0;
  logic [7:0]   mask_i = '0;
  logic [511:0] src_i = '0;
  logic [511:0] old_i = '0;
  logic         valid_o;
  logic [511:0] dst_o;
  logic         inv_o;
  logic         den_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  mant_vec dut (.*);

  always #10 clk_i = ~clk_i;

  logic [63:0] vals [NV] = '{
    64'h0000_0000_0000_0000, 64'h8000_0000_0000_0000, 64'h7FF0_0000_0000_0000,
    64'hFFF0_0000_0000_0000, 64'h7FF8_0000_0000_0001, 64'h7FF0_0000_0000_0001,
    64'hFFF4_0000_0000_0000, 64'h3FF0_0000_0000_0000, 64'h3FF8_0000_0000_0000,
    64'hC004_0000_0000_0000, 64'h4008_0000_0000_0000, 64'h3FE8_0000_0000_0000,
    64'h7FEF_FFFF_FFFF_FFFF, 64'h0010_0000_0000_0000, 64'h8020_1234_5678_9ABC,
    64'h0000_0000_0000_0001, 64'h0008_0000_0000_0000, 64'h0004_0000_0000_0000,
    64'h800C_0000_0000_0003, 64'h4000_0000_0000_0000, 64'h3FE0_0000_0000_0000,
    64'h3FD8_0000_0000_0001, 64'h000F_FFFF_FFFF_FFFF, 64'h0002_8000_0000_0000
  };

  function automatic void ref_mant(input logic [63:0] x, input logic [3:0] imm,
                                   output logic [63:0] r, output logic inv,
                                   output logic den);
    logic s;
    logic [10:0] e;
    logic [51:0] f;
    logic [52:0] m;
    logic kneg;
    int eb;
    s = x[63]; e = x[62:52]; f = x[51:0];
    inv = 1'b0; den = 1'b0; m = '0; eb = 0; kneg = 1'b0;
    if (e == 11'h7FF && f != 0) begin
      r = x | 64'h0008_0000_0000_0000;
      inv = ~f[51];
    end else if (s && imm[3] && !(e == 0 && f == 0)) begin
      r = 64'hFFF8_0000_0000_0000;
      inv = 1'b1;
      den = (e == 0);
    end else if (e == 11'h7FF || (e == 0 && f == 0)) begin
      r = (s && !imm[2]) ? 64'hBFF0_0000_0000_0000 : 64'h3FF0_0000_0000_0000;
    end else begin
      if (e == 0) begin
        m = {1'b0, f}; eb = 1;
        while (!m[52]) begin m = m << 1; eb = eb - 1; end
        den = 1'b1;
      end else begin
        m = {1'b1, f}; eb = int'(e);
      end
      case (imm[1:0])
        2'd0: kneg = 1'b0;
        2'd1: kneg = (eb % 2 == 0);
        2'd2: kneg = 1'b1;
        default: kneg = m[51];
      endcase
      r = {s & ~imm[2], (kneg ? 11'h3FE : 11'h3FF), m[51:0]};
    end
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  task automatic check(string tag, logic ok, logic [511:0] act, logic [511:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_vec(string tag, logic [3:0] imm, logic [1:0] vl, logic men,
                         logic zm, logic bc, logic [7:0] mk, logic [511:0] src,
                         logic [511:0] old);
    logic [511:0] exp_d;
    logic exp_i, exp_n;
    exp_d = '0; exp_i = 1'b0; exp_n = 1'b0;
    for (int j = 0; j < 8; j++) begin
      logic [63:0] r;
      logic li, ln;
      if (j < (2 << vl)) begin
        if (!men || mk[j]) begin
          ref_mant(bc ? src[63:0] : src[j*64 +: 64], imm, r, li, ln);
          exp_d[j*64 +: 64] = r;
          exp_i |= li; exp_n |= ln;
        end else begin
          exp_d[j*64 +: 64] = zm ? 64'h0 : old[j*64 +: 64];
        end
      end
    end
    @(negedge clk_i);
    valid_i = 1'b1; imm_i = imm; vl_sel_i = vl; mask_en_i = men;
    zero_mask_i = zm; bcast_i = bc; mask_i = mk; src_i = src; old_i = old;
    @(negedge clk_i);
    valid_i = 1'b0;
    check(tag, (dst_o === exp_d) && valid_o && (inv_o === exp_i) && (den_o === exp_n),
          {dst_o[509:0], inv_o, den_o}, {exp_d[509:0], exp_i, exp_n});
  endtask

  initial begin
    logic [511:0] s, o;
    repeat (3) @(negedge clk_i);
    check("R11 reset", (dst_o === '0) && !valid_o && !inv_o && !den_o, dst_o, '0);
    rst_ni = 1'b1;

    // R1 R2 R3 R4 R5 R6: all immediates against special, normal, subnormal values
    for (int i = 0; i < NV; i++) begin
      for (int im = 0; im < 16; im++) begin
        s = '0;
        for (int j = 0; j < 8; j++) s[j*64 +: 64] = vals[(i + 7 * j) % NV];
        run_vec("R1/R2/R3/R4/R5/R6 sweep", 4'(im), 2'd0, 1'b0, 1'b0, 1'b0, 8'h00, s, '1);
      end
    end

    // R7: lane count decode, upper bits cleared
    for (int v = 0; v < 4; v++) begin
      for (int im = 0; im < 16; im += 5) begin
        s = '0;
        for (int j = 0; j < 8; j++) s[j*64 +: 64] = vals[(3 * j + v + 7) % NV];
        run_vec("R7 length", 4'(im), 2'(v), 1'b0, 1'b0, 1'b0, 8'h00, s, '1);
      end
    end

    // R8 R10: every mask pattern, merge and zero; lane 3 SNaN, lane 5 subnormal
    s = '0; o = '0;
    for (int j = 0; j < 8; j++) begin
      s[j*64 +: 64] = vals[(5 * j + 8) % NV];
      o[j*64 +: 64] = {32'hA5A5_0000 + 32'(j), 32'h1234_5678};
    end
    s[3*64 +: 64] = 64'h7FF0_0000_0000_0001;
    s[5*64 +: 64] = 64'h0000_0000_0000_0001;
    for (int zm = 0; zm < 2; zm++) begin
      for (int mk = 0; mk < 256; mk++) begin
        run_vec("R8/R10 mask", 4'h1, 2'd2, 1'b1, 1'(zm), 1'b0, 8'(mk), s, o);
      end
    end
    // R10: SNaN and subnormal lanes beyond the active length raise nothing
    run_vec("R10 inactive", 4'h0, 2'd0, 1'b0, 1'b0, 1'b0, 8'hFF, s, o);

    // R9: broadcast of lane 0
    for (int i = 0; i < NV; i += 3) begin
      s[63:0] = vals[i];
      run_vec("R9 bcast", 4'h3, 2'd2, 1'b0, 1'b0, 1'b1, 8'h00, s, o);
    end

    // R11: outputs hold while valid_i is low
    run_vec("R11 op", 4'h2, 2'd1, 1'b0, 1'b0, 1'b0, 8'h00, s, o);
    o = dst_o;
    @(negedge clk_i);
    src_i = ~src_i; imm_i = 4'hF; vl_sel_i = 2'd2;
    repeat (2) @(negedge clk_i);
    check("R11 hold", (dst_o === o) && !valid_o, dst_o, o);

    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
    end
  end
endmodule